// File: doc/BRIEF.md
# Over-Temperature Alert Generator with Fault Queue

This block watches a stream of signed temperature results and drives a single alert pin. Each result is compared with a high limit and a lower release limit. A fault counter demands a programmable number of consecutive qualifying results before the alert changes state, so that isolated noisy readings do not toggle the pin. The pin level for "alert" is programmable, so the pin can be active high or active low.

Two behaviours are offered. In comparator mode the alert follows temperature with hysteresis: it sets on high readings and releases on low ones. In interrupt mode the alert is an event flag. It sets when the temperature crosses the high limit upward or the release limit downward, and it is cleared by any register read. When the converter runs on demand (single-shot operation), comparator-mode release happens only on a trigger strobe, and only if the latest result lies below the release limit.

Limit storage, register decoding and the converter itself sit outside the block. The block takes strobes and levels from those units.

Top module: `tempalert_top`

## Requirements
- R1: A result counts as high when it is at or above `lim_high`. In comparator mode with the alert idle, the alert sets on the result that completes the required run of consecutive high results. The pin changes in the cycle after that result's strobe.
- R2: `cfg_queue` selects the run length: 2'b00 = 1, 2'b01 = 2, 2'b10 = 4 and 2'b11 = 6 consecutive qualifying results.
- R3: Any result that does not qualify for the pending transition restarts the run count from zero.
- R4: In comparator mode under continuous conversion, an active alert releases after the required run of results strictly below `lim_release`. Results at or above `lim_release` do not release it.
- R5: `cfg_active_high` = 1 drives the pin high when alerting and low when idle. With 0 the levels are reversed.
- R6: In interrupt mode, a `reg_read` strobe clears an asserted alert.
- R7: In interrupt mode, after an upward crossing has been flagged, the next flag needs a qualified run of results below `lim_release`. High results in between do not flag. After that downward flag, the next flag needs high results again.
- R8: In comparator mode with `cfg_single` = 1, conversions never release an active alert. A `single_trig` strobe releases it only if the most recent result was below `lim_release`.
- R9: In comparator mode, `reg_read` has no effect on the pin.
- R10: While `rst` is high, the alert is idle and the run count is zero. The pin shows the idle level.
- R11: All comparisons treat the result and both limits as signed two's-complement values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is present |
| res_temp | input | TEMP_W | Signed conversion result |
| lim_high | input | TEMP_W | Signed alert-set limit |
| lim_release | input | TEMP_W | Signed hysteresis release limit |
| cfg_intr_mode | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| cfg_active_high | input | 1 | Alert pin polarity |
| cfg_queue | input | 2 | Consecutive-fault run length select |
| cfg_single | input | 1 | Single-shot conversion operation |
| reg_read | input | 1 | Strobe: some register was read |
| single_trig | input | 1 | Strobe: single-shot trigger write |
| alert_pin | output | 1 | Alert pin level |

## Verification
A corrupted run counter shows up at the pin as an alert that arrives one or more conversions early or late. It becomes visible in the cycle after the result strobe that should (or should not) have completed the run. A wrong direction state in interrupt mode is exposed by the first read-cleared flag that fails to reappear on the opposite crossing. A stale last-result flag in single-shot mode shows up on the very next trigger strobe, as a release that does not happen or one that should not.

// File: rtl/ota_pkg.sv
package ota_pkg;

    parameter int TEMP_W = 13;
    localparam int QCNT_W = 3;

    typedef enum logic {
        MODE_COMP = 1'b0,
        MODE_INTR = 1'b1
    } alert_mode_e;

    typedef enum logic {
        SEEK_HIGH = 1'b0,
        SEEK_LOW  = 1'b1
    } seek_e;

    typedef struct packed {
        logic high;
        logic low;
    } cmp_flags_t;

    function automatic logic [QCNT_W-1:0] queue_depth(input logic [1:0] sel);
        logic [QCNT_W-1:0] d;
        case (sel)
            2'b00:   d = QCNT_W'(1);
            2'b01:   d = QCNT_W'(2);
            2'b10:   d = QCNT_W'(4);
            default: d = QCNT_W'(6);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ota_classify.sv
module ota_classify
    import ota_pkg::*;
#(
    parameter int TW = TEMP_W
) (
    input  logic signed [TW-1:0] temp,
    input  logic signed [TW-1:0] lim_hi,
    input  logic signed [TW-1:0] lim_lo,
    output cmp_flags_t           flags
);
    always_comb begin
        flags.high = (temp >= lim_hi);
        flags.low  = (temp <  lim_lo);
    end
endmodule

// File: rtl/ota_fault_queue.sv
module ota_fault_queue
    import ota_pkg::*;
#(
    parameter int CW = QCNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    input  logic          fault,
    input  logic [CW-1:0] depth,
    output logic          run_done,
    output logic [CW-1:0] count
);
    logic [CW-1:0] count_q;
    logic [CW:0]   count_inc;

    always_comb begin
        count_inc = {1'b0, count_q} + 1'b1;
        run_done  = sample && fault && (count_inc >= {1'b0, depth});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (sample) begin
            if (!fault || run_done) count_q <= '0;
            else                    count_q <= count_inc[CW-1:0];
        end
    end

    assign count = count_q;
endmodule

// File: rtl/ota_alert_fsm.sv
module ota_alert_fsm
    import ota_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  alert_mode_e mode,
    input  logic        single_op,
    input  logic        sample,
    input  cmp_flags_t  flags,
    input  logic        run_done,
    input  logic        rd_strobe,
    input  logic        trig,
    output logic        fault,
    output logic        alert
);
    logic  alert_q;
    seek_e seek_q;
    logic  last_low_q;
    logic  want_high;
    logic  count_en;

    always_comb begin
        if (mode == MODE_COMP) begin
            want_high = !alert_q;
            count_en  = !(single_op && alert_q);
        end else begin
            want_high = (seek_q == SEEK_HIGH);
            count_en  = 1'b1;
        end
        fault = count_en && (want_high ? flags.high : flags.low);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alert_q    <= 1'b0;
            seek_q     <= SEEK_HIGH;
            last_low_q <= 1'b0;
        end else begin
            if (sample) last_low_q <= flags.low;
            if (mode == MODE_COMP) begin
                seek_q <= SEEK_HIGH;
                if (run_done)
                    alert_q <= !alert_q;
                else if (single_op && trig && alert_q && last_low_q)
                    alert_q <= 1'b0;
            end else begin
                if (run_done) begin
                    alert_q <= 1'b1;
                    seek_q  <= (seek_q == SEEK_HIGH) ? SEEK_LOW : SEEK_HIGH;
                end else if (rd_strobe) begin
                    alert_q <= 1'b0;
                end
            end
        end
    end

    assign alert = alert_q;
endmodule

// File: rtl/tempalert_top.sv
module tempalert_top
    import ota_pkg::*;
#(
    parameter int TW = TEMP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [TW-1:0] res_temp,
    input  logic [TW-1:0] lim_high,
    input  logic [TW-1:0] lim_release,
    input  logic          cfg_intr_mode,
    input  logic          cfg_active_high,
    input  logic [1:0]    cfg_queue,
    input  logic          cfg_single,
    input  logic          reg_read,
    input  logic          single_trig,
    output logic          alert_pin
);
    cmp_flags_t        flags;
    logic              fault;
    logic              run_done;
    logic              alert_st;
    logic [QCNT_W-1:0] depth;
    logic [QCNT_W-1:0] run_count;
    alert_mode_e       mode;

    assign mode  = alert_mode_e'(cfg_intr_mode);
    assign depth = queue_depth(cfg_queue);

    ota_classify #(.TW(TW)) u_cls (
        .temp   ($signed(res_temp)),
        .lim_hi ($signed(lim_high)),
        .lim_lo ($signed(lim_release)),
        .flags  (flags)
    );

    ota_fault_queue #(.CW(QCNT_W)) u_fq (
        .clk      (clk),
        .rst      (rst),
        .sample   (res_valid),
        .fault    (fault),
        .depth    (depth),
        .run_done (run_done),
        .count    (run_count)
    );

    ota_alert_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .single_op (cfg_single),
        .sample    (res_valid),
        .flags     (flags),
        .run_done  (run_done),
        .rd_strobe (reg_read),
        .trig      (single_trig),
        .fault     (fault),
        .alert     (alert_st)
    );

    assign alert_pin = cfg_active_high ? alert_st : !alert_st;
endmodule

// File: rtl/ota_checker.sv
module ota_checker
    import ota_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_intr_mode,
    input logic              cfg_single,
    input logic              res_valid,
    input logic              reg_read,
    input logic              single_trig,
    input logic              alert_st,
    input logic              run_done,
    input logic [QCNT_W-1:0] run_count,
    input logic [QCNT_W-1:0] depth
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!alert_st && run_count == '0));                          // R10

    AST_COUNT_BELOW_DEPTH: assert property (@(posedge clk) disable iff (rst)
        run_count < depth);                                               // R2

    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_st) |-> $past(run_done));                             // R1

    AST_INTR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cfg_intr_mode && reg_read && !run_done) |=> !alert_st);          // R6

    AST_COMP_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_intr_mode && reg_read && !res_valid && !single_trig)
        |=> $stable(alert_st));                                           // R9

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_intr_mode && cfg_single && alert_st && !single_trig)
        |=> alert_st);                                                    // R8
endmodule

bind tempalert_top ota_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_intr_mode (cfg_intr_mode),
    .cfg_single    (cfg_single),
    .res_valid     (res_valid),
    .reg_read      (reg_read),
    .single_trig   (single_trig),
    .alert_st      (alert_st),
    .run_done      (run_done),
    .run_count     (run_count),
    .depth         (depth)
);

// File: tb/test_tempalert_top.sv
module test_tempalert_top;
    localparam int TW = 13;
    localparam logic [1:0] OP_CONV = 2'd0, OP_READ = 2'd1, OP_TRIG = 2'd2, OP_RST = 2'd3;

    typedef struct packed {
        logic [1:0]           op;
        logic                 intr;
        logic                 ahi;
        logic                 single;
        logic [1:0]           q;
        logic signed [TW-1:0] t;
        logic                 exp;
        logic [3:0]           req;
    } vec_t;

    localparam int NV = 35;
    // limits for the table: high = 100, release = 90
    localparam vec_t VEC [NV] = '{
        // comparator, run of 2, active high, continuous
        '{OP_RST , 1'b0, 1'b1, 1'b0, 2'b01, 13'sd0  , 1'b0, 4'd10}, // R10
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd105, 1'b0, 4'd2 }, // R2 one of two
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd95 , 1'b0, 4'd3 }, // R3 restart
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd105, 1'b0, 4'd3 }, // R3
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd100, 1'b1, 4'd1 }, // R1 equal to limit
        '{OP_READ, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd0  , 1'b1, 4'd9 }, // R9
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd95 , 1'b1, 4'd4 }, // R4 band
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd80 , 1'b1, 4'd4 }, // R4
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd95 , 1'b1, 4'd3 }, // R3
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd80 , 1'b1, 4'd4 }, // R4
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b01, 13'sd89 , 1'b0, 4'd4 }, // R4 release
        // interrupt, run of 1, active low
        '{OP_RST , 1'b1, 1'b0, 1'b0, 2'b00, 13'sd0  , 1'b1, 4'd5 }, // R5 idle high
        '{OP_CONV, 1'b1, 1'b0, 1'b0, 2'b00, 13'sd120, 1'b0, 4'd5 }, // R5
        '{OP_READ, 1'b1, 1'b0, 1'b0, 2'b00, 13'sd0  , 1'b1, 4'd6 }, // R6
        '{OP_CONV, 1'b1, 1'b0, 1'b0, 2'b00, 13'sd120, 1'b1, 4'd7 }, // R7
        '{OP_CONV, 1'b1, 1'b0, 1'b0, 2'b00, 13'sd85 , 1'b0, 4'd7 }, // R7 down flag
        '{OP_READ, 1'b1, 1'b0, 1'b0, 2'b00, 13'sd0  , 1'b1, 4'd6 }, // R6
        '{OP_CONV, 1'b1, 1'b0, 1'b0, 2'b00, 13'sd85 , 1'b1, 4'd7 }, // R7
        // comparator single-shot, run of 4
        '{OP_RST , 1'b0, 1'b1, 1'b1, 2'b10, 13'sd0  , 1'b0, 4'd10}, // R10
        '{OP_CONV, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd110, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd110, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd110, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd110, 1'b1, 4'd2 }, // R2 fourth
        '{OP_CONV, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd70 , 1'b1, 4'd8 }, // R8
        '{OP_CONV, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd95 , 1'b1, 4'd8 }, // R8
        '{OP_TRIG, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd0  , 1'b1, 4'd8 }, // R8 latest not low
        '{OP_CONV, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd70 , 1'b1, 4'd8 }, // R8
        '{OP_TRIG, 1'b0, 1'b1, 1'b1, 2'b10, 13'sd0  , 1'b0, 4'd8 }, // R8 release
        // comparator, run of 6
        '{OP_RST , 1'b0, 1'b1, 1'b0, 2'b11, 13'sd0  , 1'b0, 4'd10}, // R10
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b11, 13'sd101, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b11, 13'sd101, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b11, 13'sd101, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b11, 13'sd101, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b11, 13'sd101, 1'b0, 4'd2 }, // R2
        '{OP_CONV, 1'b0, 1'b1, 1'b0, 2'b11, 13'sd101, 1'b1, 4'd2 }  // R2 sixth
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          res_valid = 1'b0;
    logic [TW-1:0] res_temp = '0;
    logic [TW-1:0] lim_high = 13'sd100;
    logic [TW-1:0] lim_release = 13'sd90;
    logic          cfg_intr_mode = 1'b0;
    logic          cfg_active_high = 1'b1;
    logic [1:0]    cfg_queue = 2'b00;
    logic          cfg_single = 1'b0;
    logic          reg_read = 1'b0;
    logic          single_trig = 1'b0;
    logic          alert_pin;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tempalert_top #(.TW(TW)) i_tempalert_top (.*);

    task automatic check(input logic exp, input int req);
        n_cmp++;
        if (alert_pin !== exp) begin
            n_bad++;
            $display("FAIL R%0d: alert_pin=%b expected %b at %0t", req, alert_pin, exp, $time);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        cfg_intr_mode   = v.intr;
        cfg_active_high = v.ahi;
        cfg_single      = v.single;
        cfg_queue       = v.q;
        case (v.op)
            OP_RST: begin
                rst = 1'b1;
                @(negedge clk);
                @(negedge clk);
                rst = 1'b0;
            end
            OP_CONV: begin res_valid = 1'b1; res_temp = v.t; end
            OP_READ: reg_read = 1'b1;
            default: single_trig = 1'b1;
        endcase
        @(negedge clk);
        res_valid = 1'b0; reg_read = 1'b0; single_trig = 1'b0;
        check(v.exp, int'(v.req));
    endtask

    function automatic vec_t mk(input logic [1:0] op, input logic signed [TW-1:0] t,
                                input logic exp, input logic [3:0] req);
        vec_t v;
        v.op = op; v.intr = 1'b0; v.ahi = 1'b1; v.single = 1'b0; v.q = 2'b00;
        v.t = t; v.exp = exp; v.req = req;
        return v;
    endfunction

    initial begin
        // R10: pin idle while reset is held
        repeat (2) @(negedge clk);
        check(1'b0, 10);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R11: negative limits, signed comparison
        lim_high    = -13'sd20;
        lim_release = -13'sd40;
        apply(mk(OP_RST, 13'sd0, 1'b0, 4'd10));  // R10
        apply(mk(OP_CONV, -13'sd25, 1'b0, 4'd11)); // R11 below high limit
        apply(mk(OP_CONV, 13'sd5, 1'b1, 4'd11));   // R11 positive over negative limit
        apply(mk(OP_CONV, -13'sd30, 1'b1, 4'd11)); // R11 inside band
        apply(mk(OP_CONV, -13'sd50, 1'b0, 4'd11)); // R11 release

        // R10: reset while alerting returns pin to idle
        apply(mk(OP_CONV, 13'sd0, 1'b1, 4'd1));    // R1
        apply(mk(OP_RST, 13'sd0, 1'b0, 4'd10));    // R10

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule